// File: doc/BRIEF.md
# Multiplexed GPIO Pin Controller

This block runs a bank of I/O pins. Each pin is driven from a general-purpose output register or is handed to one of up to two peripheral functions. Which pins can be handed over, and to which peripherals, is fixed per pin by elaboration-time masks. A small register port on the always-on bus clock writes the pin configuration. The same port reads back the pin levels and the latched change events.

Input sampling, level readback and change detection run only while the controller clock enable `ctl_clk_en` is high. This input models the gateable controller clock as a clock enable in the bus clock domain. Configuration writes land whether or not that enable is high. While it is low, the input samples freeze, no change events are recorded and the interrupt output stays low. The interrupt output feeds an external interrupt controller.

Top module: `pinmux_gpio_ctrl`

## Requirements
- R1: After reset every pin is in GPIO mode with peripheral A selected, `pad_oe` and `pad_out` are all 0, all interrupts are masked, `irq` is 0, and reads at 0x20 and 0x2C return 0.
- R2: A write at offset 0x10 sets, and a write at 0x14 clears, the output-enable bit of each pin whose `bus_wdata` bit is 1. Offsets 0x18 and 0x1C do the same for the output-level bit. On a pin in GPIO mode, `pad_oe` and `pad_out` show these bits from the cycle after the write.
- R3: A write at 0x04 hands each selected multiplexed pin to a peripheral, and a write at 0x00 returns it to GPIO. A handed-over pin copies `pa_out`/`pa_oe` while its B-select bit is 0. It copies `pb_out`/`pb_oe` after a 1 is written for it at 0x0C. A write at 0x08 clears its B-select bit.
- R4: On a pin whose `PERIPH_A_PINS` bit is 0, a write at 0x04 has no effect: the pin stays under GPIO control. On a pin whose `PERIPH_B_PINS` bit is 0, a write at 0x0C has no effect: the pin stays on peripheral A.
- R5: Every configuration write takes effect in the next cycle whatever the value of `ctl_clk_en`.
- R6: A read at 0x20 returns the synchronized pin levels. A pin change is visible after two enabled clock edges. While `ctl_clk_en` is 0, the value read is frozen at the last sample.
- R7: A pin whose synchronized level differs from its previous sample sets its status bit on the third enabled edge after the change, whether or not its interrupt is enabled. A read at 0x2C returns the status and clears it at that clock edge. An event arriving at that same edge is kept.
- R8: `irq` is 1 exactly when `ctl_clk_en` is 1 and some pin has both its status bit and its mask bit set. A write at 0x24 sets mask bits and a write at 0x28 clears them. While `ctl_clk_en` is 0, no event is recorded and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_clk_en | input | 1 | Controller clock enable (gates sampling and interrupt) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Read data, valid in the cycle of `bus_rd` |
| pad_in | input | NUM_PINS | Pin input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pin output levels |
| pad_oe | output | NUM_PINS | Pin output enables |
| pa_out | input | NUM_PINS | Peripheral A output levels |
| pa_oe | input | NUM_PINS | Peripheral A output enables |
| pb_out | input | NUM_PINS | Peripheral B output levels |
| pb_oe | input | NUM_PINS | Peripheral B output enables |
| irq | output | 1 | Controller interrupt request |

## Verification
A wrong mode or B-select bit shows on `pad_out`/`pad_oe` in the cycle after the write that set it, once the peripheral inputs differ from the GPIO registers. A sampler that keeps running while gated shows up as a changed level read or a spurious status bit once the enable returns. A synchronizer with the wrong depth shifts the level read and the status bit by a cycle, which the bench catches by reading on each edge after a change. A mask or status error shows on `irq` within three cycles of a pin change. It also shows when the enable is dropped and raised again.

// File: rtl/pinmux_gpio_pkg.sv
package pinmux_gpio_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_GPIO_ON  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_GPIO_OFF = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_SEL_A    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_SEL_B    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_DRV_ON   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_DRV_OFF  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_LVL_HI   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_LVL_LO   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_PIN_LVL  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_IRQ_ON   = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_IRQ_OFF  = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_EVT      = 6'h2C;

  typedef struct packed {
    logic val;
    logic en;
  } pad_drv_t;

  // Chooses the source that drives one pad.
  function automatic pad_drv_t pick_drive(input logic gpio_mode, input logic use_b,
                                          input pad_drv_t gpio_d, input pad_drv_t pa_d,
                                          input pad_drv_t pb_d);
    if (gpio_mode) return gpio_d;
    if (use_b)     return pb_d;
    return pa_d;
  endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] PERIPH_A_PINS = '1,
  parameter logic [NUM_PINS-1:0] PERIPH_B_PINS = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] gpio_mode,
  output logic [NUM_PINS-1:0] use_b,
  output logic [NUM_PINS-1:0] drv_en,
  output logic [NUM_PINS-1:0] drv_val,
  output logic [NUM_PINS-1:0] irq_mask
);

  localparam logic [NUM_PINS-1:0] ALL_PINS  = '1;
  localparam logic [NUM_PINS-1:0] CAN_MUX   = PERIPH_A_PINS;
  localparam logic [NUM_PINS-1:0] CAN_SEL_B = PERIPH_A_PINS & PERIPH_B_PINS;

  function automatic logic [NUM_PINS-1:0] bits_set(input logic [NUM_PINS-1:0] cur,
                                                   input logic [NUM_PINS-1:0] req,
                                                   input logic [NUM_PINS-1:0] allow);
    return cur | (req & allow);
  endfunction

  function automatic logic [NUM_PINS-1:0] bits_clr(input logic [NUM_PINS-1:0] cur,
                                                   input logic [NUM_PINS-1:0] req,
                                                   input logic [NUM_PINS-1:0] allow);
    return cur & ~(req & allow);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_mode <= ALL_PINS;
      use_b     <= '0;
      drv_en    <= '0;
      drv_val   <= '0;
      irq_mask  <= '0;
    end else if (wr) begin
      case (addr)
        OFF_GPIO_ON:  gpio_mode <= bits_set(gpio_mode, wdata, ALL_PINS);
        OFF_GPIO_OFF: gpio_mode <= bits_clr(gpio_mode, wdata, CAN_MUX);
        OFF_SEL_A:    use_b     <= bits_clr(use_b, wdata, ALL_PINS);
        OFF_SEL_B:    use_b     <= bits_set(use_b, wdata, CAN_SEL_B);
        OFF_DRV_ON:   drv_en    <= bits_set(drv_en, wdata, ALL_PINS);
        OFF_DRV_OFF:  drv_en    <= bits_clr(drv_en, wdata, ALL_PINS);
        OFF_LVL_HI:   drv_val   <= bits_set(drv_val, wdata, ALL_PINS);
        OFF_LVL_LO:   drv_val   <= bits_clr(drv_val, wdata, ALL_PINS);
        OFF_IRQ_ON:   irq_mask  <= bits_set(irq_mask, wdata, ALL_PINS);
        OFF_IRQ_OFF:  irq_mask  <= bits_clr(irq_mask, wdata, ALL_PINS);
        default: ;
      endcase
    end
  end

  // R4
  gpio_only_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_GPIO_OFF) |=> ((gpio_mode & ~CAN_MUX) == $past(gpio_mode & ~CAN_MUX)));

  // R4
  no_b_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_SEL_B) |=> ((use_b & ~CAN_SEL_B) == $past(use_b & ~CAN_SEL_B)));

  // R5
  level_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_LVL_HI) |=> ((drv_val & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/pinmux_in_sampler.sv
module pinmux_in_sampler #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] change_evt
);

  logic [NUM_PINS-1:0] sync_q1;
  logic [NUM_PINS-1:0] sync_q2;
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q1 <= '0;
      sync_q2 <= '0;
      prev_q  <= '0;
    end else if (ctl_en) begin
      sync_q1 <= pad_in;
      sync_q2 <= sync_q1;
      prev_q  <= sync_q2;
    end
  end

  assign level      = sync_q2;
  assign change_evt = ctl_en ? (sync_q2 ^ prev_q) : '0;

  // R6
  frozen_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> ($stable(sync_q2) && $stable(prev_q)));

endmodule

// File: rtl/pinmux_evt_status.sv
module pinmux_evt_status #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic [NUM_PINS-1:0] change_evt,
  input  logic                rd_clear,
  output logic [NUM_PINS-1:0] status
);

  logic [NUM_PINS-1:0] kept;

  assign kept = rd_clear ? '0 : status;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= kept | change_evt;
  end

  // R7
  evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (change_evt != '0) |=> ((status & $past(change_evt)) == $past(change_evt)));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && change_evt == '0) |=> (status == '0));

  // R8
  quiet_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (change_evt == '0));

endmodule

// File: rtl/pinmux_pad_mux.sv
module pinmux_pad_mux
  import pinmux_gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] PERIPH_A_PINS = '1,
  parameter logic [NUM_PINS-1:0] PERIPH_B_PINS = '1
) (
  input  logic [NUM_PINS-1:0] gpio_mode,
  input  logic [NUM_PINS-1:0] use_b,
  input  logic [NUM_PINS-1:0] drv_en,
  input  logic [NUM_PINS-1:0] drv_val,
  input  logic [NUM_PINS-1:0] pa_out,
  input  logic [NUM_PINS-1:0] pa_oe,
  input  logic [NUM_PINS-1:0] pb_out,
  input  logic [NUM_PINS-1:0] pb_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam bit MUXED = PERIPH_A_PINS[p];
    localparam bit HAS_B = PERIPH_A_PINS[p] & PERIPH_B_PINS[p];
    pad_drv_t drv;
    assign drv = pick_drive(gpio_mode[p] | !MUXED, use_b[p] & HAS_B,
                            '{val: drv_val[p], en: drv_en[p]},
                            '{val: pa_out[p],  en: pa_oe[p]},
                            '{val: pb_out[p],  en: pb_oe[p]});
    assign pad_out[p] = drv.val;
    assign pad_oe[p]  = drv.en;
  end

endmodule

// File: rtl/pinmux_gpio_ctrl.sv
module pinmux_gpio_ctrl
  import pinmux_gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] PERIPH_A_PINS = 8'hF6,
  parameter logic [NUM_PINS-1:0] PERIPH_B_PINS = 8'hCC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_clk_en,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] pa_out,
  input  logic [NUM_PINS-1:0] pa_oe,
  input  logic [NUM_PINS-1:0] pb_out,
  input  logic [NUM_PINS-1:0] pb_oe,
  output logic                irq
);

  logic [NUM_PINS-1:0] gpio_mode, use_b, drv_en, drv_val, irq_mask;
  logic [NUM_PINS-1:0] level, change_evt, status;
  logic                evt_read;

  assign evt_read = bus_rd && (bus_addr == OFF_EVT);

  pinmux_cfg_regs #(
    .NUM_PINS(NUM_PINS), .PERIPH_A_PINS(PERIPH_A_PINS), .PERIPH_B_PINS(PERIPH_B_PINS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .gpio_mode(gpio_mode), .use_b(use_b), .drv_en(drv_en), .drv_val(drv_val),
    .irq_mask(irq_mask)
  );

  pinmux_in_sampler #(.NUM_PINS(NUM_PINS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_clk_en), .pad_in(pad_in),
    .level(level), .change_evt(change_evt)
  );

  pinmux_evt_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_clk_en), .change_evt(change_evt),
    .rd_clear(evt_read), .status(status)
  );

  pinmux_pad_mux #(
    .NUM_PINS(NUM_PINS), .PERIPH_A_PINS(PERIPH_A_PINS), .PERIPH_B_PINS(PERIPH_B_PINS)
  ) u_mux (
    .gpio_mode(gpio_mode), .use_b(use_b), .drv_en(drv_en), .drv_val(drv_val),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFF_PIN_LVL)  bus_rdata = level;
      else if (bus_addr == OFF_EVT) bus_rdata = status;
    end
  end

  assign irq = ctl_clk_en & (|(status & irq_mask));

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));

endmodule

// File: tb/test_pinmux_gpio_ctrl.sv
`timescale 1ns/1ps
module test_pinmux_gpio_ctrl;

  localparam int N = 8;
  localparam logic [N-1:0] A_PINS = 8'hF6;
  localparam logic [N-1:0] B_PINS = 8'hCC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk_en = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic [N-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic irq;

  int checks = 0;
  int failures = 0;

  // bench model of the configuration
  logic [N-1:0] m_gpio = '1, m_b = '0, m_oe = '0, m_od = '0, m_mask = '0, m_st = '0;

  always #2 clk = ~clk;

  pinmux_gpio_ctrl #(.NUM_PINS(N), .PERIPH_A_PINS(A_PINS), .PERIPH_B_PINS(B_PINS))
  i_pinmux_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_clk_en(ctl_clk_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out),
    .pb_oe(pb_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_out(input logic want_oe);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) begin
      if (!A_PINS[p] || m_gpio[p]) r[p] = want_oe ? m_oe[p] : m_od[p];
      else if (m_b[p] && A_PINS[p] && B_PINS[p]) r[p] = want_oe ? pb_oe[p] : pb_out[p];
      else r[p] = want_oe ? pa_oe[p] : pa_out[p];
    end
    return r;
  endfunction

  function automatic logic exp_irq();
    return ctl_clk_en && ((m_st & m_mask) != 0);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a)
      6'h00: m_gpio = m_gpio | d;
      6'h04: m_gpio = m_gpio & ~(d & A_PINS);
      6'h08: m_b    = m_b & ~d;
      6'h0C: m_b    = m_b | (d & A_PINS & B_PINS);
      6'h10: m_oe   = m_oe | d;
      6'h14: m_oe   = m_oe & ~d;
      6'h18: m_od   = m_od | d;
      6'h1C: m_od   = m_od & ~d;
      6'h24: m_mask = m_mask | d;
      6'h28: m_mask = m_mask & ~d;
      default: ;
    endcase
    @(posedge clk); #1 bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [N-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_pads(input string tag);
    check(tag, pad_out, exp_out(1'b0));
    check(tag, pad_oe, exp_out(1'b1));
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    logic [N-1:0] prev_pins;
    void'($urandom(32'h5EED_0042));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    reg_read(6'h20, rd); check("R1 level", rd, 8'h00);
    reg_read(6'h2C, rd); check("R1 status", rd, 8'h00);

    // R5 + R2: config writes with the controller clock off
    reg_write(6'h18, 8'hF0); check_pads("R5 R2 level set");
    reg_write(6'h10, 8'h5A); check_pads("R5 R2 oe set");
    reg_write(6'h1C, 8'h30); check_pads("R2 level clear");
    reg_write(6'h14, 8'h18); check_pads("R2 oe clear");

    // R3 peripheral A then B
    pa_out = 8'h33; pa_oe = 8'hF0; pb_out = 8'hAA; pb_oe = 8'h0F;
    reg_write(6'h04, 8'hFF); check_pads("R3 periph A");
    // R4 GPIO-only pins 0 and 3 keep GPIO drive
    check("R4 gpio-only out", pad_out & ~A_PINS, m_od & ~A_PINS);
    check("R4 gpio-only oe", pad_oe & ~A_PINS, m_oe & ~A_PINS);
    reg_write(6'h0C, 8'hFF); check_pads("R3 periph B");
    // R4 pins 1,4,5 have no B: stay on A; pin 3 GPIO-only
    check("R4 no-B pins on A", pad_out & A_PINS & ~B_PINS, pa_out & A_PINS & ~B_PINS);
    reg_write(6'h08, 8'h40); check_pads("R3 back to A");
    reg_write(6'h00, 8'h0F); check_pads("R3 back to GPIO");

    // R2 R3 random configuration
    for (int i = 0; i < 60; i++) begin
      logic [5:0] offs [10] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h24, 6'h28};
      pa_out = N'($urandom); pa_oe = N'($urandom); pb_out = N'($urandom); pb_oe = N'($urandom);
      reg_write(offs[$urandom % 10], N'($urandom));
      check_pads("R2 R3 random");
    end
    reg_write(6'h28, 8'hFF);

    // enable controller clock, pins quiet
    ctl_clk_en = 1'b1;
    wait_cyc(3);
    reg_read(6'h2C, rd); check("R7 no spurious", rd, 8'h00);

    // R6 latency and R7 capture
    pad_in = 8'hA5;
    reg_read(6'h20, rd); check("R6 edge0", rd, 8'h00);
    reg_read(6'h20, rd); check("R6 edge1", rd, 8'h00);
    check("R8 masked irq", {7'b0, irq}, 8'h00);
    reg_read(6'h20, rd); check("R6 edge2", rd, 8'hA5);
    check("R8 masked irq", {7'b0, irq}, 8'h00);
    reg_read(6'h2C, rd); check("R7 status", rd, 8'hA5);
    reg_read(6'h2C, rd); check("R7 cleared", rd, 8'h00);

    // R7 unmasked pins still latch; R8 mask
    reg_write(6'h24, 8'h01);
    pad_in = 8'hA7; wait_cyc(3);
    check("R8 other pin masked", {7'b0, irq}, 8'h00);
    reg_read(6'h2C, rd); check("R7 unmasked latch", rd, 8'h02);
    pad_in = 8'hA6; wait_cyc(3);
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    ctl_clk_en = 1'b0; #1;
    check("R8 irq gated", {7'b0, irq}, 8'h00);
    wait_cyc(1);
    ctl_clk_en = 1'b1; #1;
    check("R8 irq back", {7'b0, irq}, 8'h01);
    wait_cyc(1);
    reg_read(6'h2C, rd); check("R7 read status", rd, 8'h01);
    check("R8 irq after clear", {7'b0, irq}, 8'h00);

    // R6 frozen while gated, R8 no events while gated
    ctl_clk_en = 1'b0;
    pad_in = 8'h5A; wait_cyc(5);
    reg_read(6'h20, rd); check("R6 frozen level", rd, 8'hA6);
    reg_read(6'h2C, rd); check("R8 no gated events", rd, 8'h00);
    ctl_clk_en = 1'b1; wait_cyc(3);
    reg_read(6'h20, rd); check("R6 resumed level", rd, 8'h5A);
    reg_read(6'h2C, rd); check("R7 resumed events", rd, 8'hFC);

    // random pin changes with random masks
    prev_pins = 8'h5A;
    m_st = '0;
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] nxt;
      nxt = N'($urandom);
      reg_write(($urandom % 2) ? 6'h24 : 6'h28, N'($urandom));
      pad_in = nxt; wait_cyc(3);
      m_st = prev_pins ^ nxt;
      check("R8 random irq", {7'b0, irq}, {7'b0, exp_irq()});
      reg_read(6'h20, rd); check("R6 random level", rd, nxt);
      reg_read(6'h2C, rd); check("R7 random status", rd, m_st);
      m_st = '0;
      prev_pins = nxt;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule